// File: doc/BRIEF.md
# Bit-Sliced Four-Function Integer ALU

This block is the arithmetic and logic unit used by the register-to-register operation class of a small 64-bit teaching processor. It is purely combinational. Instructions of that class carry a 4-bit class code and a 4-bit function code. The function code picks one of four operations: add, subtract, bitwise AND or bitwise XOR.

The datapath is a row of identical 1-bit slices joined by a ripple carry. Each slice can complement its A or B operand. It forms an AND, an XOR and a full-adder sum from the two operands, and a 2-bit select chooses which of the three is passed out. A small decoder derives every slice control from the two low function-code bits. The top level adds a guard on class and function code, and it also forms the zero, sign, overflow and carry-out indications.

The block has no streaming interface. Its operands and results are plain combinational pins that settle within the same cycle, so no valid/ready exchange or back-pressure applies. The surrounding pipeline registers the outputs in the usual way.

Top module: `alu_bitslice_top`

## Requirements
- R1: With class code 6 and function code 0, `alu_res` equals `src_a + src_b` modulo 2^64.
- R2: With class code 6 and function code 1, `alu_res` equals `src_b - src_a` modulo 2^64, with operand A being the one subtracted.
- R3: With class code 6 and function code 2, `alu_res` equals `src_a & src_b`.
- R4: With class code 6 and function code 3, `alu_res` equals `src_a ^ src_b`.
- R5: If the class code is not 6, or function code bits 3:2 are not both 0, then `op_ok` is 0 and `alu_res`, `zf`, `sf`, `of` and `cout` are all 0. In every other case `op_ok` is 1.
- R6: For a valid operation, `zf` is 1 exactly when all 64 bits of `alu_res` are 0.
- R7: For a valid operation, `sf` equals bit 63 of `alu_res`.
- R8: For add, `of` is 1 when A and B have equal sign bits and the sign bit of the result differs from them. For subtract, `of` is 1 when the sign bits of A and B differ and the sign bit of the result differs from that of B. For AND and XOR, `of` is 0.
- R9: For add and subtract, `cout` is the carry out of the most significant slice, that is bit 64 of `A+B` or of `B+~A+1`. For AND and XOR, `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 4 | Instruction class code; 6 selects this unit |
| op_func | input | 4 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| src_a | input | 64 | Operand A (subtrahend for subtract) |
| src_b | input | 64 | Operand B |
| alu_res | output | 64 | Result, zero when the operation is not valid |
| op_ok | output | 1 | High when class and function code name a supported operation |
| zf | output | 1 | Result is zero |
| sf | output | 1 | Result sign bit |
| of | output | 1 | Signed overflow for add and subtract |
| cout | output | 1 | Carry out of the top slice for add and subtract |

## Verification
The cases that need the most care are those where a result condition and an arithmetic exception happen in the same evaluation. One example is a signed overflow whose wrapped result is exactly zero, such as adding two most-negative values, which sets zero, overflow and carry together. Another is a subtract of equal operands, which raises zero and carry but not overflow. These are applied as directed vectors next to random operands whose sign bits are often forced equal or opposite. Each flag is compared with a value the bench works out independently, with 65-bit arithmetic and sign-bit rules.

// File: rtl/alu_bitslice_pkg.sv
package alu_bitslice_pkg;
  localparam logic [3:0] CLASS_OP = 4'd6;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_XOR = 2'b01,
    SEL_SUM = 2'b10,
    SEL_NONE = 2'b11
  } slice_sel_e;

  typedef struct packed {
    logic       inv_a;
    logic       inv_b;
    logic       carry_in;
    slice_sel_e sel;
    logic       arith;
  } slice_ctrl_t;
endpackage

// File: rtl/alu_func_decode.sv
module alu_func_decode
  import alu_bitslice_pkg::*;
(
  input  logic [1:0]  fn_lo,
  output slice_ctrl_t ctrl
);
  always_comb begin
    ctrl.inv_b    = 1'b0;
    ctrl.inv_a    = (fn_lo == 2'd1);
    ctrl.carry_in = (fn_lo == 2'd1);
    ctrl.arith    = ~fn_lo[1];
    unique case (fn_lo)
      2'd2:    ctrl.sel = SEL_AND;
      2'd3:    ctrl.sel = SEL_XOR;
      default: ctrl.sel = SEL_SUM;
    endcase
  end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_bitslice_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       inv_a,
  input  logic       inv_b,
  input  logic       cin,
  input  slice_sel_e sel,
  output logic       y,
  output logic       a_eff,
  output logic       cout
);
  logic b_eff, g_and, g_xor, s;

  assign a_eff = a ^ inv_a;
  assign b_eff = b ^ inv_b;
  assign g_and = a_eff & b_eff;
  assign g_xor = a_eff ^ b_eff;
  assign s     = g_xor ^ cin;
  assign cout  = g_and | (g_xor & cin);

  always_comb begin
    unique case (sel)
      SEL_AND: y = g_and;
      SEL_XOR: y = g_xor;
      SEL_SUM: y = s;
      default: y = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_slice_row.sv
module alu_slice_row
  import alu_bitslice_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  slice_ctrl_t      ctrl,
  output logic [WIDTH-1:0] y,
  output logic             a_top_eff,
  output logic             carry_top
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] a_eff_v;

  assign chain[0] = ctrl.carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    alu_bit_slice u_slice (
      .a     (a[i]),
      .b     (b[i]),
      .inv_a (ctrl.inv_a),
      .inv_b (ctrl.inv_b),
      .cin   (chain[i]),
      .sel   (ctrl.sel),
      .y     (y[i]),
      .a_eff (a_eff_v[i]),
      .cout  (chain[i+1])
    );
  end

  assign a_top_eff = a_eff_v[MSB];
  assign carry_top = chain[WIDTH];
endmodule

// File: rtl/alu_bitslice_top.sv
module alu_bitslice_top
  import alu_bitslice_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [3:0]       op_class,
  input  logic [3:0]       op_func,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic [WIDTH-1:0] alu_res,
  output logic             op_ok,
  output logic             zf,
  output logic             sf,
  output logic             of,
  output logic             cout
);
  localparam int MSB = WIDTH - 1;

  slice_ctrl_t      ctrl;
  logic [WIDTH-1:0] row_y;
  logic             a_top, c_top, ovf_raw;

  alu_func_decode u_dec (
    .fn_lo (op_func[1:0]),
    .ctrl  (ctrl)
  );

  alu_slice_row #(.WIDTH(WIDTH)) u_row (
    .a         (src_a),
    .b         (src_b),
    .ctrl      (ctrl),
    .y         (row_y),
    .a_top_eff (a_top),
    .carry_top (c_top)
  );

  assign op_ok   = (op_class == CLASS_OP) && (op_func[3:2] == 2'b00);
  assign alu_res = op_ok ? row_y : '0;
  assign ovf_raw = (a_top == src_b[MSB]) && (row_y[MSB] != src_b[MSB]);
  assign zf      = op_ok && (alu_res == '0);
  assign sf      = op_ok && alu_res[MSB];
  assign of      = op_ok && ctrl.arith && ovf_raw;
  assign cout    = op_ok && ctrl.arith && c_top;
endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
  parameter int WIDTH = 64
) (
  input logic [3:0]       op_class,
  input logic [3:0]       op_func,
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic [WIDTH-1:0] alu_res,
  input logic             op_ok,
  input logic             of,
  input logic             cout
);
  logic good;
  assign good = (op_class == 4'd6) && (op_func[3:2] == 2'b00);

  always_comb begin
    if (good && op_func[1:0] == 2'd0)
      p_add_sum_r1: assert (alu_res == src_a + src_b);
    if (good && op_func[1:0] == 2'd1)
      p_sub_diff_r2: assert (alu_res == src_b - src_a);
    if (good && op_func[1:0] == 2'd2)
      p_and_bits_r3: assert (alu_res == (src_a & src_b));
    if (good && op_func[1:0] == 2'd3)
      p_xor_bits_r4: assert (alu_res == (src_a ^ src_b));
    if (!good)
      p_blocked_quiet_r5: assert (!op_ok && alu_res == '0 && !cout);
    if (good && op_func[1])
      p_no_overflow_r8: assert (!of);
    if (good && op_func[1])
      p_no_carry_r9: assert (!cout);
  end
endmodule

bind alu_bitslice_top alu_bitslice_chk #(.WIDTH(WIDTH)) u_chk (
  .op_class (op_class),
  .op_func  (op_func),
  .src_a    (src_a),
  .src_b    (src_b),
  .alu_res  (alu_res),
  .op_ok    (op_ok),
  .of       (of),
  .cout     (cout)
);

// File: tb/alu_bitslice_top_test.sv
module alu_bitslice_top_test;
  localparam int W = 64;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]   op_class, op_func;
  logic [W-1:0] src_a, src_b, alu_res;
  logic         op_ok, zf, sf, of, cout;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  alu_bitslice_top #(.WIDTH(W)) uut (
    .op_class (op_class),
    .op_func  (op_func),
    .src_a    (src_a),
    .src_b    (src_b),
    .alu_res  (alu_res),
    .op_ok    (op_ok),
    .zf       (zf),
    .sf       (sf),
    .of       (of),
    .cout     (cout)
  );

  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  function automatic logic [W:0] ref_wide(input logic [3:0] c, input logic [3:0] f,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
    if (c != 4'd6 || f[3:2] != 2'b00) return '0;
    case (f[1:0])
      2'd0:    return {1'b0, a} + {1'b0, b};
      2'd1:    return {1'b0, b} + {1'b0, ~a} + 65'd1;
      2'd2:    return {1'b0, a & b};
      default: return {1'b0, a ^ b};
    endcase
  endfunction

  function automatic logic ref_of(input logic [3:0] c, input logic [3:0] f,
                                  input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [W-1:0] r);
    if (c != 4'd6 || f[3:2] != 2'b00) return 1'b0;
    if (f[1:0] == 2'd0) return (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    if (f[1:0] == 2'd1) return (a[W-1] != b[W-1]) && (r[W-1] != b[W-1]);
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (class %0d func %0d a %h b %h)",
               tag, act, exp, op_class, op_func, src_a, src_b);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [3:0] f,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0]   wide;
    logic [W-1:0] r;
    logic         ok;
    @(negedge clk);
    op_class = c; op_func = f; src_a = a; src_b = b;
    #1;
    wide = ref_wide(c, f, a, b);
    ok   = (c == 4'd6) && (f[3:2] == 2'b00);
    r    = wide[W-1:0];
    case (f[1:0])
      2'd0: chk("R1 add", alu_res, r);
      2'd1: chk("R2 sub", alu_res, r);
      2'd2: chk("R3 and", alu_res, r);
      default: chk("R4 xor", alu_res, r);
    endcase
    chk("R5 op_ok", W'(op_ok), W'(ok));
    chk("R6 zf", W'(zf), W'(ok && r == '0));
    chk("R7 sf", W'(sf), W'(ok && r[W-1]));
    chk("R8 of", W'(of), W'(ref_of(c, f, a, b, r)));
    chk("R9 cout", W'(cout), W'(ok && !f[1] && wide[W]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    op_class = 4'd0; op_func = 4'd0; src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time idle inputs: class 0 must be quiet (R5)
    #1;
    chk("R5 idle res", alu_res, '0);
    chk("R5 idle ok", W'(op_ok), '0);

    // directed corners
    apply(4'd6, 4'd0, MINV, MINV);                 // R1 R6 R8 R9: zero, overflow, carry together
    apply(4'd6, 4'd0, MAXV, 64'd1);                // R8 positive overflow, R7 sign
    apply(4'd6, 4'd0, '1, 64'd1);                  // R9 carry, R6 zero, no overflow
    apply(4'd6, 4'd1, 64'h1234, 64'h1234);         // R2 equal: zero and carry, no overflow
    apply(4'd6, 4'd1, 64'd5, 64'd3);               // R2 borrow: B-A negative
    apply(4'd6, 4'd1, 64'd1, MINV);                // R8 sub overflow
    apply(4'd6, 4'd1, MINV, 64'd0);                // R8 sub overflow, negating min
    apply(4'd6, 4'd2, '1, 64'hF0F0);               // R3
    apply(4'd6, 4'd2, MINV, MINV);                 // R3 sign, R8 zero for logic
    apply(4'd6, 4'd3, '1, '1);                     // R4 zero result
    apply(4'd6, 4'd3, MINV, 64'd0);                // R4 sign, R9 none
    apply(4'd5, 4'd0, MINV, MINV);                 // R5 wrong class
    apply(4'd6, 4'd4, 64'd7, 64'd9);               // R5 function bit 2
    apply(4'd6, 4'd9, '1, '1);                     // R5 function bit 3
    apply(4'd15, 4'd3, '1, 64'd0);                 // R5

    for (int i = 0; i < 4000; i++) begin
      logic [3:0]   c, f;
      logic [W-1:0] a, b;
      c = ($urandom % 8 == 0) ? 4'($urandom) : 4'd6;
      f = ($urandom % 8 == 0) ? 4'($urandom) : {2'b00, 2'($urandom)};
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case ($urandom % 6)
        0: b[W-1] = a[W-1];
        1: b[W-1] = ~a[W-1];
        2: b = a;
        3: b = ~a;
        default: ;
      endcase
      apply(c, f, a, b);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule